// File: doc/BRIEF.md
# Mixed-Sign Indexed Dot Product Unit

This unit performs a vector-wide 4-way byte dot product with 32-bit accumulation, where one byte operand is signed and the other is unsigned. The vector is split into 32-bit lanes. Each lane adds, to its own accumulator word, the four products of its own four bytes of the first source with four bytes of the second source. The second-source bytes are not taken lane by lane. One 32-bit group per 128-bit segment is chosen by a 2-bit index, and that group is broadcast to every lane of the segment.

An operation carries a 6-bit opcode that picks the sign pairing, the group index, an active operand size and a maximum vector size, both in bytes. The unit computes the active lanes. It drives zero on every other lane and produces a per-lane write mask that covers the vector up to the maximum size. An illegal combination raises an error flag and produces no data. The unit takes one operation per cycle once it is out of reset and returns the registered result one cycle later, together with a single-cycle valid pulse.

Top module: `dotp_mixed_idx`

## Requirements
- R1: Each active 32-bit lane result equals its accumulator word plus the sum of the four byte products, wrapping modulo 2^32 with no saturation.
- R2: Opcode 6'b000111 treats the first-source bytes as signed (sign-extended) and the second-source bytes as unsigned (zero-extended).
- R3: Opcode 6'b000110 treats the first-source bytes as unsigned and the second-source bytes as signed.
- R4: Lane l, in segment s = l/4, uses the second-source bytes at byte offsets 16*s + 4*idx_i to 16*s + 4*idx_i + 3. Byte k of the group multiplies byte k of the lane.
- R5: An active size of 8 bytes is legal. Only lanes 0 and 1 are then computed, and both use the group of segment 0.
- R6: On a legal operation, every lane at byte offset 4*l >= opr_sz_i outputs zero, up to the full vector width.
- R7: On a legal operation, bit l of wmask_o is 1 exactly when 4*l < max_sz_i.
- R8: The operation is illegal, and sets err_o with all-zero data and mask, in any of these cases: the opcode is neither of the two codes; opr_sz_i is neither 8 nor a nonzero multiple of 16 no larger than the vector; max_sz_i is not a nonzero multiple of 16 no larger than the vector; max_sz_i < opr_sz_i; or opr_sz_i is 8 and idx_i is 2 or 3.
- R9: An operation is accepted when in_valid_i and in_ready_o are both high. Its result appears on the outputs one cycle later with out_valid_o high for exactly that cycle. out_valid_o is low in the cycle after an edge with no acceptance.
- R10: While rst_ni is low, out_valid_o, in_ready_o, err_o, wmask_o and d_o are all zero. in_ready_o goes high on the first clock edge after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Operation present |
| in_ready_o | output | 1 | Unit can accept an operation |
| op_i | input | 6 | Opcode selecting the sign pairing |
| idx_i | input | 2 | Group index within each 128-bit segment |
| opr_sz_i | input | $clog2(VLEN/8)+1 | Active operand size in bytes |
| max_sz_i | input | $clog2(VLEN/8)+1 | Maximum vector size in bytes |
| n_i | input | VLEN | First source bytes |
| m_i | input | VLEN | Second source bytes (indexed) |
| acc_i | input | VLEN | Accumulator words |
| out_valid_o | output | 1 | One-cycle result pulse |
| err_o | output | 1 | Illegal operation flag |
| wmask_o | output | VLEN/32 | Per-lane write mask |
| d_o | output | VLEN | Result words |

## Verification
The assertions assume that in_valid_i is held low while reset is active, and that a size on the inputs is only meaningful in the cycle the operation is accepted. The bench drives every operation half a cycle before the accepting edge and keeps valid low during reset. It then sweeps both opcodes, all four index values and every legal size pair of a 256-bit vector. Random operands and saturated byte patterns (-128, 127 and 255) are used so that the wrap and sign-extension cases are reached. Illegal opcodes, sizes and index values are sent on purpose to exercise the error path.

// File: rtl/dotp_pkg.sv
package dotp_pkg;
  typedef enum logic [5:0] {
    OP_UN_SG = 6'b000110,   // first unsigned, second signed
    OP_SG_UN = 6'b000111    // first signed, second unsigned
  } dotp_op_e;

  localparam int unsigned LANE_W = 32;
  localparam int unsigned SEG_W  = 128;
  localparam int unsigned LANES_PER_SEG = SEG_W / LANE_W;

  function automatic logic signed [8:0] ext_byte(input logic [7:0] b, input logic sgn);
    return sgn ? $signed({b[7], b}) : $signed({1'b0, b});
  endfunction
endpackage

// File: rtl/dotp_lane.sv
module dotp_lane
  import dotp_pkg::*;
(
  input  logic [31:0] n_w_i,
  input  logic [31:0] m_w_i,
  input  logic [31:0] acc_i,
  input  logic        n_sgn_i,
  output logic [31:0] sum_o
);
  logic signed [17:0] prod [4];

  for (genvar k = 0; k < 4; k++) begin : g_byte
    logic signed [8:0] ne, me;
    assign ne = ext_byte(n_w_i[8*k +: 8], n_sgn_i);
    assign me = ext_byte(m_w_i[8*k +: 8], ~n_sgn_i);
    assign prod[k] = ne * me;
  end

  always_comb begin
    sum_o = acc_i;
    for (int k = 0; k < 4; k++) sum_o = sum_o + 32'(prod[k]);
  end
endmodule

// File: rtl/dotp_cfg.sv
module dotp_cfg
  import dotp_pkg::*;
#(
  parameter int unsigned NB  = 32,
  parameter int unsigned NL  = NB / 4,
  parameter int unsigned SZW = $clog2(NB) + 1
) (
  input  logic [5:0]     op_i,
  input  logic [1:0]     idx_i,
  input  logic [SZW-1:0] opr_sz_i,
  input  logic [SZW-1:0] max_sz_i,
  output logic           err_o,
  output logic           n_sgn_o,
  output logic [NL-1:0]  act_o,
  output logic [NL-1:0]  wr_o
);
  logic op_ok, opr8, opr_ok, max_ok, idx_ok;

  assign op_ok  = (op_i == OP_UN_SG) || (op_i == OP_SG_UN);
  assign opr8   = (opr_sz_i == SZW'(8));
  assign opr_ok = opr8 || (opr_sz_i[3:0] == 4'd0 && opr_sz_i != '0 && int'(opr_sz_i) <= NB);
  assign max_ok = (max_sz_i[3:0] == 4'd0) && (max_sz_i != '0) && (int'(max_sz_i) <= NB)
                  && (max_sz_i >= opr_sz_i);
  // 8-byte form only holds groups 0 and 1
  assign idx_ok = !(opr8 && idx_i[1]);

  assign err_o   = !(op_ok && opr_ok && max_ok && idx_ok);
  assign n_sgn_o = (op_i == OP_SG_UN);

  for (genvar l = 0; l < NL; l++) begin : g_lane
    assign act_o[l] = int'(opr_sz_i) > 4 * l;
    assign wr_o[l]  = int'(max_sz_i) > 4 * l;
  end
endmodule

// File: rtl/dotp_mixed_idx.sv
module dotp_mixed_idx
  import dotp_pkg::*;
#(
  parameter int unsigned VLEN = 256,               // multiple of 128, at most 2048
  localparam int unsigned NB  = VLEN / 8,
  localparam int unsigned NL  = VLEN / LANE_W,
  localparam int unsigned SZW = $clog2(NB) + 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            in_valid_i,
  output logic            in_ready_o,
  input  logic [5:0]      op_i,
  input  logic [1:0]      idx_i,
  input  logic [SZW-1:0]  opr_sz_i,
  input  logic [SZW-1:0]  max_sz_i,
  input  logic [VLEN-1:0] n_i,
  input  logic [VLEN-1:0] m_i,
  input  logic [VLEN-1:0] acc_i,
  output logic            out_valid_o,
  output logic            err_o,
  output logic [NL-1:0]   wmask_o,
  output logic [VLEN-1:0] d_o
);
  logic            cfg_err, n_sgn, accept;
  logic [NL-1:0]   act, wr;
  logic [VLEN-1:0] d_nxt;

  dotp_cfg #(.NB(NB), .NL(NL), .SZW(SZW)) i_cfg (
    .op_i     (op_i),
    .idx_i    (idx_i),
    .opr_sz_i (opr_sz_i),
    .max_sz_i (max_sz_i),
    .err_o    (cfg_err),
    .n_sgn_o  (n_sgn),
    .act_o    (act),
    .wr_o     (wr)
  );

  for (genvar l = 0; l < NL; l++) begin : g_lane
    localparam int unsigned SEG = l / LANES_PER_SEG;
    logic [31:0] m_grp, sum;
    assign m_grp = m_i[SEG*SEG_W + 32*idx_i +: 32];

    dotp_lane i_lane (
      .n_w_i   (n_i[32*l +: 32]),
      .m_w_i   (m_grp),
      .acc_i   (acc_i[32*l +: 32]),
      .n_sgn_i (n_sgn),
      .sum_o   (sum)
    );

    assign d_nxt[32*l +: 32] = (cfg_err || !act[l]) ? 32'd0 : sum;

    // lanes past the active size read back as zero
    p_tail_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (out_valid_o && !err_o && int'($past(opr_sz_i)) <= 4 * l) |-> (d_o[32*l +: 32] == 32'd0));
  end

  assign accept = in_valid_i && in_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_ready_o  <= 1'b0;
      out_valid_o <= 1'b0;
      err_o       <= 1'b0;
      wmask_o     <= '0;
      d_o         <= '0;
    end else begin
      in_ready_o  <= 1'b1;
      out_valid_o <= accept;
      if (accept) begin
        err_o   <= cfg_err;
        wmask_o <= cfg_err ? '0 : wr;
        d_o     <= d_nxt;
      end
    end
  end

  p_valid_after_accept_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> out_valid_o);

  p_no_valid_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !accept |=> !out_valid_o);

  p_err_clean_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && err_o) |-> (d_o == '0 && wmask_o == '0));

  p_short_idx_err_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && opr_sz_i == SZW'(8) && idx_i[1]) |=> err_o);

  p_mask_prefix_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !err_o) |-> ((wmask_o & (wmask_o + NL'(1))) == '0 && wmask_o[0]));
endmodule

// File: tb/test_dotp_mixed_idx.sv
module test_dotp_mixed_idx;
  localparam int VLEN = 256;
  localparam int NB   = VLEN / 8;
  localparam int NL   = VLEN / 32;
  localparam int SZW  = $clog2(NB) + 1;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic            in_valid_i = 1'b0;
  logic            in_ready_o;
  logic [5:0]      op_i = '0;
  logic [1:0]      idx_i = '0;
  logic [SZW-1:0]  opr_sz_i = '0;
  logic [SZW-1:0]  max_sz_i = '0;
  logic [VLEN-1:0] n_i = '0, m_i = '0, acc_i = '0;
  logic            out_valid_o, err_o;
  logic [NL-1:0]   wmask_o;
  logic [VLEN-1:0] d_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  dotp_mixed_idx #(.VLEN(VLEN)) i_dotp_mixed_idx (
    .clk_i, .rst_ni, .in_valid_i, .in_ready_o, .op_i, .idx_i, .opr_sz_i, .max_sz_i,
    .n_i, .m_i, .acc_i, .out_valid_o, .err_o, .wmask_o, .d_o
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] model_lane(int l, logic [5:0] op, int idx);
    int s = acc_i[32*l +: 32];
    int seg = l / 4;
    for (int k = 0; k < 4; k++) begin
      logic [7:0] nb = n_i[8*(4*l + k) +: 8];
      logic [7:0] mb = m_i[8*(16*seg + 4*idx + k) +: 8];
      int nv, mv;
      if (op == 6'b000111) begin nv = int'($signed(nb)); mv = int'(mb); end
      else                 begin nv = int'(nb);          mv = int'($signed(mb)); end
      s = s + nv * mv;
    end
    return s;
  endfunction

  function automatic bit model_err(logic [5:0] op, int idx, int opr, int mx);
    bit opr_ok = (opr == 8) || (opr % 16 == 0 && opr != 0 && opr <= NB);
    bit max_ok = (mx % 16 == 0) && mx != 0 && mx <= NB && mx >= opr;
    return !(op == 6'b000110 || op == 6'b000111) || !opr_ok || !max_ok || (opr == 8 && idx >= 2);
  endfunction

  // drive before an edge, check half a cycle after it
  task automatic do_op(input logic [5:0] op, input int idx, input int opr, input int mx, input string tag);
    bit e;
    @(negedge clk_i);
    in_valid_i = 1'b1; op_i = op; idx_i = 2'(idx);
    opr_sz_i = SZW'(opr); max_sz_i = SZW'(mx);
    @(negedge clk_i);
    e = model_err(op, idx, opr, mx);
    check(out_valid_o === 1'b1, "R9 valid", 32'(out_valid_o), 32'd1);
    check(err_o === e, "R8 err", 32'(err_o), 32'(e));
    for (int l = 0; l < NL; l++) begin
      logic [31:0] exp;
      string req;
      if (e)                 begin exp = '0; req = "R8 data"; end
      else if (4 * l >= opr) begin exp = '0; req = (opr == 8) ? "R5 tail" : "R6 tail"; end
      else begin exp = model_lane(l, op, idx); req = tag; end
      check(d_o[32*l +: 32] === exp, req, d_o[32*l +: 32], exp);
    end
    begin
      logic [NL-1:0] wm;
      for (int l = 0; l < NL; l++) wm[l] = !e && (4 * l < mx);
      check(wmask_o === wm, "R7 mask", 32'(wmask_o), 32'(wm));
    end
  endtask

  task automatic rand_ops();
    for (int w = 0; w < NL; w++) begin
      n_i[32*w +: 32] = $urandom; m_i[32*w +: 32] = $urandom; acc_i[32*w +: 32] = $urandom;
    end
  endtask

  initial begin
    #(10 * 150000);
    errors++;
    $display("FAIL watchdog: actual %h expected %h", 32'd0, 32'd1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int sizes[5][2] = '{'{8, 16}, '{8, 32}, '{16, 16}, '{16, 32}, '{32, 32}};
    // R10 reset state
    repeat (3) @(negedge clk_i);
    check(out_valid_o === 1'b0 && err_o === 1'b0, "R10 reset valid/err", 32'(out_valid_o), 32'd0);
    check(in_ready_o === 1'b0, "R10 reset ready", 32'(in_ready_o), 32'd0);
    check(d_o === '0 && wmask_o === '0, "R10 reset data", d_o[31:0], 32'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(in_ready_o === 1'b1, "R10 ready after reset", 32'(in_ready_o), 32'd1);

    // R4 index sweep over both pairings and every size pair
    for (int op = 6; op <= 7; op++)
      for (int idx = 0; idx < 4; idx++)
        for (int sz = 0; sz < 5; sz++)
          for (int r = 0; r < 3; r++) begin
            rand_ops();
            do_op(6'(op), idx, sizes[sz][0], sizes[sz][1], op == 7 ? "R2 R4 lane" : "R3 R4 lane");
          end

    // R2 extremes: -128 * 255
    n_i = {NB{8'h80}}; m_i = {NB{8'hFF}}; acc_i = '0;
    do_op(6'b000111, 1, 32, 32, "R2 extreme");
    // R3 extremes: 255 * -128
    n_i = {NB{8'hFF}}; m_i = {NB{8'h80}};
    do_op(6'b000110, 3, 32, 32, "R3 extreme");
    // R3 vs R2 with the same bytes differ in sign handling
    n_i = {NB{8'hFF}}; m_i = {NB{8'hFF}}; acc_i = {NL{32'd5}};
    do_op(6'b000111, 0, 32, 32, "R2 minus one");
    do_op(6'b000110, 0, 32, 32, "R3 minus one");
    // R1 wrap past the top of the 32-bit range
    n_i = {NB{8'h7F}}; m_i = {NB{8'hFF}}; acc_i = {NL{32'h7FFF_FFFF}};
    do_op(6'b000111, 2, 32, 32, "R1 wrap");
    n_i = {NB{8'h80}}; m_i = {NB{8'hFF}}; acc_i = {NL{32'h8000_0000}};
    do_op(6'b000111, 2, 32, 32, "R1 wrap low");

    // R8 illegal cases
    rand_ops();
    do_op(6'b000101, 0, 32, 32, "R8");
    do_op(6'b100111, 0, 32, 32, "R8");
    do_op(6'b000111, 0, 12, 32, "R8");
    do_op(6'b000111, 0, 0, 32, "R8");
    do_op(6'b000110, 0, 48, 48, "R8");
    do_op(6'b000110, 0, 32, 16, "R8");
    do_op(6'b000110, 0, 8, 8, "R8");
    do_op(6'b000111, 2, 8, 16, "R8");
    do_op(6'b000111, 3, 8, 32, "R8");
    // legal op after an error recovers
    do_op(6'b000111, 1, 16, 32, "R2 after error");

    // R9 no pulse without a new operation
    in_valid_i = 1'b0;
    @(negedge clk_i);
    check(out_valid_o === 1'b0, "R9 idle", 32'(out_valid_o), 32'd0);
    @(negedge clk_i);
    check(out_valid_o === 1'b0, "R9 idle hold", 32'(out_valid_o), 32'd0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule